// File: doc/BRIEF.md
# Metaframe Lock Frame Synchronizer

This block takes a stream of 66-bit blocks (a 2-bit header plus a 64-bit payload) from an upstream block aligner. It finds where each fixed-length metaframe starts and reports when that alignment can be trusted. It first hunts for a synchronization word. It then confirms that the word comes back at the same offset in following metaframes, and declares lock only after four such words in a row. Once locked, it stops watching sync words. Instead it compares each metaframe's scrambler state word with the state the descrambler supplies for that block. Three mismatches in a row drop lock and send the block back to hunting.

The blocks themselves are forwarded unchanged with one register of delay. A downstream CRC-32 stage receives the data and the lock flag aligned with each other. The lock flag rises in the same output cycle as the block that completed acquisition, and falls in the same output cycle as the block that caused the loss.

The controller has three states. SEARCH examines every valid block for a sync word. VERIFY counts sync words at the expected metaframe offset. LOCKED checks scrambler state words. The transitions are as follows:
- search-to-verify: a sync word is found.
- verify-to-locked: the required sync count is reached.
- verify-to-search: a sync word is missing at its offset.
- locked-to-search: the mismatch limit is reached.
- any-to-search: reset, or the block-lock input goes low.

Top module: `fsync_metaframe_lock`

## Requirements
- R1: While reset is asserted, and right after it is released, frame_lock_o and out_valid_o are low and the controller is in SEARCH.
- R2: A sync word is a block with header 2'b10 and payload 64'h78F6_78F6_78F6_78F6. In SEARCH, any valid sync word moves the controller to VERIFY and marks that block as metaframe position 0.
- R3: frame_lock_o rises in the output cycle of the fourth consecutive sync word. The sync words must be spaced exactly MF_LEN valid blocks apart.
- R4: In VERIFY, a block at position 0 that is not a sync word returns the controller to SEARCH and clears the sync count, so hunting resumes on the very next block. Sync words at any other position are ignored.
- R5: In LOCKED, the block at position 1 is the scrambler state word. It matches only if the header is 2'b10, bits [63:58] equal 6'h0A and bits [57:0] equal dscr_state_i in that same cycle. Anything else at that position counts as a mismatch.
- R6: The third consecutive scrambler-word mismatch drops frame_lock_o in the output cycle of that mismatching block and returns the controller to SEARCH.
- R7: A matching scrambler word clears the mismatch count, so isolated pairs of mismatches never drop lock.
- R8: When blk_lock_i is low on a clock edge, frame_lock_o is low after that edge, and the sync and mismatch counts are cleared. Regaining lock afterwards needs four fresh sync words.
- R9: Every input block is forwarded one cycle later on out_valid_o, out_hdr_o and out_data_o, whatever the controller state. A cycle with in_valid_i low gives out_valid_o low.
- R10: Cycles with in_valid_i low neither advance the metaframe position nor change the state, as long as blk_lock_i stays high.
- R11: In LOCKED, a missing or corrupted sync word at position 0 has no effect on frame_lock_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_lock_i | input | 1 | Block alignment status from the upstream aligner |
| in_valid_i | input | 1 | A block is present this cycle |
| in_hdr_i | input | 2 | Block header |
| in_data_i | input | 64 | Block payload |
| dscr_state_i | input | 58 | Current descrambler state, for the block presented this cycle |
| frame_lock_o | output | 1 | Metaframe lock status |
| out_valid_o | output | 1 | Forwarded block valid |
| out_hdr_o | output | 2 | Forwarded block header |
| out_data_o | output | 64 | Forwarded block payload |

## Verification
Several properties are checked by assertions on every cycle:
- a rise of lock always follows a valid sync word;
- a fall of lock always follows a dropped block lock or a block that failed the scrambler-word comparison;
- blk_lock_i low always clears lock;
- idle cycles never move lock;
- forwarded data is always exactly one cycle behind the input;
- neither run counter ever reaches its limit.

Other behaviours can only be shown by the bench's scenarios:
- that lock arrives exactly on the fourth aligned sync word and not earlier;
- that misaligned sync words are ignored;
- that a match between mismatches saves the lock;
- that a sync word one block after a miss is picked up at once;
- that sync words are disregarded while locked.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

    localparam int BLK_W       = 64;
    localparam int HDR_W       = 2;
    localparam int SCR_STATE_W = 58;
    localparam int SCR_TYPE_W  = BLK_W - SCR_STATE_W;

    localparam logic [HDR_W-1:0]      CTRL_HDR     = 2'b10;
    localparam logic [BLK_W-1:0]      SYNC_PAYLOAD = 64'h78F6_78F6_78F6_78F6;
    localparam logic [SCR_TYPE_W-1:0] SCR_TYPE     = 6'h0A;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } fsync_state_e;

endpackage

// File: rtl/fsync_word_cmp.sv
module fsync_word_cmp
    import fsync_pkg::*;
(
    input  logic [HDR_W-1:0]       hdr_i,
    input  logic [BLK_W-1:0]       data_i,
    input  logic [SCR_STATE_W-1:0] ref_state_i,
    output logic                   is_sync_o,
    output logic                   scr_ok_o
);

    logic ctrl_hdr;

    always_comb begin
        ctrl_hdr  = (hdr_i == CTRL_HDR);
        is_sync_o = ctrl_hdr && (data_i == SYNC_PAYLOAD);
        scr_ok_o  = ctrl_hdr
                 && (data_i[BLK_W-1:SCR_STATE_W] == SCR_TYPE)
                 && (data_i[SCR_STATE_W-1:0] == ref_state_i);
    end

endmodule

// File: rtl/fsync_pos_ctr.sv
module fsync_pos_ctr #(
    parameter int MF_LEN = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic adv_i,
    output logic at_sync_o,
    output logic at_scr_o
);

    localparam int PW = (MF_LEN > 2) ? $clog2(MF_LEN) : 1;
    localparam logic [PW-1:0] LAST = PW'(MF_LEN - 1);
    localparam logic [PW-1:0] ONE  = PW'(1);

    logic [PW-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (restart_i) begin
            pos_q <= ONE;
        end else if (adv_i) begin
            pos_q <= (pos_q == LAST) ? '0 : pos_q + ONE;
        end
    end

    assign at_sync_o = (pos_q == '0);
    assign at_scr_o  = (pos_q == ONE);

endmodule

// File: rtl/fsync_run_ctr.sv
module fsync_run_ctr #(
    parameter int LIMIT = 4,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [CW-1:0] cnt_o,
    output logic          at_last_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= inc_i ? CW'(1) : '0;
        end else if (inc_i && (cnt_q != CW'(LIMIT))) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign cnt_o     = cnt_q;
    assign at_last_o = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/fsync_metaframe_lock.sv
module fsync_metaframe_lock
    import fsync_pkg::*;
#(
    parameter int MF_LEN     = 2048,
    parameter int SYNC_NEED  = 4,
    parameter int MISS_LIMIT = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   blk_lock_i,
    input  logic                   in_valid_i,
    input  logic [HDR_W-1:0]       in_hdr_i,
    input  logic [BLK_W-1:0]       in_data_i,
    input  logic [SCR_STATE_W-1:0] dscr_state_i,
    output logic                   frame_lock_o,
    output logic                   out_valid_o,
    output logic [HDR_W-1:0]       out_hdr_o,
    output logic [BLK_W-1:0]       out_data_o
);

    localparam int MCW = $clog2(SYNC_NEED + 1);
    localparam int XCW = $clog2(MISS_LIMIT + 1);

    fsync_state_e state_q, state_d;

    logic           is_sync, scr_ok;
    logic           at_sync, at_scr;
    logic           pos_restart, pos_adv;
    logic           match_clr, match_inc, match_last;
    logic           miss_clr, miss_inc, miss_last;
    logic [MCW-1:0] match_cnt;
    logic [XCW-1:0] miss_cnt;

    fsync_word_cmp u_cmp (
        .hdr_i       (in_hdr_i),
        .data_i      (in_data_i),
        .ref_state_i (dscr_state_i),
        .is_sync_o   (is_sync),
        .scr_ok_o    (scr_ok)
    );

    fsync_pos_ctr #(.MF_LEN(MF_LEN)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (pos_restart),
        .adv_i     (pos_adv),
        .at_sync_o (at_sync),
        .at_scr_o  (at_scr)
    );

    fsync_run_ctr #(.LIMIT(SYNC_NEED)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (match_clr),
        .inc_i     (match_inc),
        .cnt_o     (match_cnt),
        .at_last_o (match_last)
    );

    fsync_run_ctr #(.LIMIT(MISS_LIMIT)) u_miss (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (miss_clr),
        .inc_i     (miss_inc),
        .cnt_o     (miss_cnt),
        .at_last_o (miss_last)
    );

    // Next-state and counter control
    always_comb begin
        state_d     = state_q;
        pos_restart = 1'b0;
        pos_adv     = 1'b0;
        match_clr   = 1'b0;
        match_inc   = 1'b0;
        miss_clr    = 1'b0;
        miss_inc    = 1'b0;
        if (!blk_lock_i) begin
            state_d   = ST_SEARCH;
            match_clr = 1'b1;
            miss_clr  = 1'b1;
        end else if (in_valid_i) begin
            unique case (state_q)
                ST_SEARCH: begin
                    match_clr = 1'b1;
                    miss_clr  = 1'b1;
                    if (is_sync) begin
                        match_inc   = 1'b1;
                        pos_restart = 1'b1;
                        state_d     = ST_VERIFY;
                    end
                end
                ST_VERIFY: begin
                    miss_clr = 1'b1;
                    pos_adv  = 1'b1;
                    if (at_sync) begin
                        if (!is_sync) begin
                            match_clr = 1'b1;
                            state_d   = ST_SEARCH;
                        end else if (match_last) begin
                            match_clr = 1'b1;
                            state_d   = ST_LOCKED;
                        end else begin
                            match_inc = 1'b1;
                        end
                    end
                end
                ST_LOCKED: begin
                    pos_adv = 1'b1;
                    if (at_scr) begin
                        if (scr_ok) begin
                            miss_clr = 1'b1;
                        end else if (miss_last) begin
                            miss_clr = 1'b1;
                            state_d  = ST_SEARCH;
                        end else begin
                            miss_inc = 1'b1;
                        end
                    end
                end
                default: begin
                    state_d   = ST_SEARCH;
                    match_clr = 1'b1;
                    miss_clr  = 1'b1;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEARCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: forwarded block and lock flag, aligned
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_lock_o <= 1'b0;
            out_valid_o  <= 1'b0;
            out_hdr_o    <= '0;
            out_data_o   <= '0;
        end else begin
            frame_lock_o <= (state_d == ST_LOCKED);
            out_valid_o  <= in_valid_i;
            out_hdr_o    <= in_hdr_i;
            out_data_o   <= in_data_i;
        end
    end

endmodule

// File: rtl/fsync_metaframe_lock_chk.sv
module fsync_metaframe_lock_chk
    import fsync_pkg::*;
#(
    parameter int SYNC_NEED  = 4,
    parameter int MISS_LIMIT = 3,
    localparam int MCW = $clog2(SYNC_NEED + 1),
    localparam int XCW = $clog2(MISS_LIMIT + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   blk_lock_i,
    input logic                   in_valid_i,
    input logic [HDR_W-1:0]       in_hdr_i,
    input logic [BLK_W-1:0]       in_data_i,
    input logic [SCR_STATE_W-1:0] dscr_state_i,
    input logic                   frame_lock_o,
    input logic                   out_valid_o,
    input logic [HDR_W-1:0]       out_hdr_o,
    input logic [BLK_W-1:0]       out_data_o,
    input logic [MCW-1:0]         match_cnt,
    input logic [XCW-1:0]         miss_cnt
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!frame_lock_o && !out_valid_o));

    assert_lock_on_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_lock_o) |-> $past(in_valid_i && blk_lock_i
            && in_hdr_i == CTRL_HDR && in_data_i == SYNC_PAYLOAD));

    assert_match_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        match_cnt < MCW'(SYNC_NEED));

    assert_loss_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_lock_o) |-> $past(!blk_lock_i || (in_valid_i
            && !(in_hdr_i == CTRL_HDR && in_data_i == {SCR_TYPE, dscr_state_i}))));

    assert_miss_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        miss_cnt < XCW'(MISS_LIMIT));

    assert_blk_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_lock_i |=> !frame_lock_o);

    assert_forward_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> (out_valid_o && out_data_o == $past(in_data_i)
            && out_hdr_o == $past(in_hdr_i)));

    assert_idle_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !out_valid_o);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_lock_i && !in_valid_i) |=> $stable(frame_lock_o));

endmodule

bind fsync_metaframe_lock fsync_metaframe_lock_chk #(
    .SYNC_NEED  (SYNC_NEED),
    .MISS_LIMIT (MISS_LIMIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .blk_lock_i   (blk_lock_i),
    .in_valid_i   (in_valid_i),
    .in_hdr_i     (in_hdr_i),
    .in_data_i    (in_data_i),
    .dscr_state_i (dscr_state_i),
    .frame_lock_o (frame_lock_o),
    .out_valid_o  (out_valid_o),
    .out_hdr_o    (out_hdr_o),
    .out_data_o   (out_data_o),
    .match_cnt    (match_cnt),
    .miss_cnt     (miss_cnt)
);

// File: tb/fsync_metaframe_lock_tb.sv
`timescale 1ns/1ps
module fsync_metaframe_lock_tb;
    import fsync_pkg::*;

    localparam int MF = 8;
    localparam logic [1:0] OP_GOOD   = 2'd0;
    localparam logic [1:0] OP_BADSCR = 2'd1;
    localparam logic [1:0] OP_NOSYNC = 2'd2;
    localparam int NTBL = 18;
    // {op, expected lock after the metaframe}
    localparam logic [2:0] TBL [NTBL] = '{
        {OP_GOOD, 1'b0}, {OP_GOOD, 1'b0}, {OP_GOOD, 1'b0}, {OP_GOOD, 1'b1},
        {OP_BADSCR, 1'b1}, {OP_BADSCR, 1'b1}, {OP_GOOD, 1'b1},
        {OP_BADSCR, 1'b1}, {OP_BADSCR, 1'b1}, {OP_BADSCR, 1'b0},
        {OP_GOOD, 1'b0}, {OP_GOOD, 1'b0}, {OP_NOSYNC, 1'b0},
        {OP_GOOD, 1'b0}, {OP_GOOD, 1'b0}, {OP_GOOD, 1'b0}, {OP_GOOD, 1'b1},
        {OP_NOSYNC, 1'b1}
    };

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   blk_lock = 1'b0;
    logic                   in_valid = 1'b0;
    logic [HDR_W-1:0]       in_hdr = '0;
    logic [BLK_W-1:0]       in_data = '0;
    logic [SCR_STATE_W-1:0] dscr = '0;
    logic                   frame_lock, out_valid;
    logic [HDR_W-1:0]       out_hdr;
    logic [BLK_W-1:0]       out_data;

    int tests = 0;
    int fails = 0;
    int seq = 0;

    always #2.5 clk = ~clk;

    fsync_metaframe_lock #(.MF_LEN(MF)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .blk_lock_i   (blk_lock),
        .in_valid_i   (in_valid),
        .in_hdr_i     (in_hdr),
        .in_data_i    (in_data),
        .dscr_state_i (dscr),
        .frame_lock_o (frame_lock),
        .out_valid_o  (out_valid),
        .out_hdr_o    (out_hdr),
        .out_data_o   (out_data)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; blk_lock = 1'b0; in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(!frame_lock, "R1 lock in reset", 64'(frame_lock), 0);
        chk(!out_valid, "R1 valid in reset", 64'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1; blk_lock = 1'b1;
        @(posedge clk); #1;
        chk(!frame_lock, "R1 lock after reset", 64'(frame_lock), 0);
    endtask

    // One valid block; forwarding is checked after the edge (R9)
    task automatic blk(input logic [1:0] h, input logic [63:0] d,
                       input logic [57:0] st);
        @(negedge clk);
        in_valid = 1'b1; blk_lock = 1'b1; in_hdr = h; in_data = d; dscr = st;
        @(posedge clk); #1;
        chk(out_valid && out_hdr == h && out_data == d, "R9 forward",
            out_data, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            @(posedge clk); #1;
            chk(!out_valid, "R9 idle valid", 64'(out_valid), 0);
        end
    endtask

    function automatic logic [63:0] filler(input int k);
        return {32'hC3C3_0000 | 32'(k & 16'hFFFF), 32'h1234_5678};
    endfunction

    task automatic sync_blk(input logic [57:0] st);
        blk(CTRL_HDR, SYNC_PAYLOAD, st);
    endtask

    task automatic fill_to_end(input int from, input logic [57:0] st);
        for (int p = from; p < MF; p++) begin
            seq++;
            blk(2'b01, filler(seq), st);
        end
    endtask

    task automatic send_mf(input logic [1:0] op, input int k);
        logic [57:0] st;
        st = 58'(64'h0155_AA00_0000_0000 + 64'(k));
        if (op == OP_NOSYNC) begin
            seq++;
            blk(2'b01, filler(seq), st);
        end else begin
            sync_blk(st);
        end
        if (op == OP_BADSCR) blk(CTRL_HDR, {SCR_TYPE, st ^ 58'h1}, st);
        else                 blk(CTRL_HDR, {SCR_TYPE, st}, st);
        fill_to_end(2, st);
    endtask

    initial begin
        #(200000 * 5);
        tests++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();

        // Table walk: R2 R3 R4 R5 R6 R7 R11
        for (int i = 0; i < NTBL; i++) begin
            send_mf(TBL[i][2:1], i);
            chk(frame_lock == TBL[i][0], "R3/R5/R6/R7/R11 table lock",
                64'(frame_lock), 64'(TBL[i][0]));
        end

        // R3: lock appears exactly with the fourth aligned sync word
        do_reset();
        for (int i = 0; i < 3; i++) send_mf(OP_GOOD, 100 + i);
        chk(!frame_lock, "R3 no lock after three", 64'(frame_lock), 0);
        sync_blk('0);
        chk(frame_lock, "R3 lock on fourth sync", 64'(frame_lock), 1);
        blk(CTRL_HDR, {SCR_TYPE, 58'h7}, 58'h7);
        fill_to_end(2, '0);

        // R6: drop in the cycle of the third mismatching block
        send_mf(OP_BADSCR, 200);
        send_mf(OP_BADSCR, 201);
        sync_blk('0);
        chk(frame_lock, "R6 still locked before third", 64'(frame_lock), 1);
        blk(CTRL_HDR, {SCR_TYPE, 58'h3}, 58'h2);
        chk(!frame_lock, "R6 lock lost on third miss", 64'(frame_lock), 0);
        fill_to_end(2, '0);

        // R4 misaligned sync ignored, R10 idle cycles do not advance position
        do_reset();
        sync_blk('0);
        seq++; blk(2'b01, filler(seq), '0);
        seq++; blk(2'b01, filler(seq), '0);
        sync_blk('0);
        fill_to_end(4, '0);
        idle(5);
        chk(!frame_lock, "R10 idle keeps state", 64'(frame_lock), 0);
        send_mf(OP_GOOD, 300);
        send_mf(OP_GOOD, 301);
        idle(3);
        sync_blk('0);
        chk(frame_lock, "R4/R10 lock on schedule", 64'(frame_lock), 1);
        fill_to_end(1, '0);
        idle(4);
        chk(frame_lock, "R10 idle holds lock", 64'(frame_lock), 1);

        // R8: block-lock drop clears lock and counts
        @(negedge clk);
        blk_lock = 1'b0; in_valid = 1'b0;
        @(posedge clk); #1;
        chk(!frame_lock, "R8 lock cleared", 64'(frame_lock), 0);
        for (int i = 0; i < 3; i++) send_mf(OP_GOOD, 400 + i);
        chk(!frame_lock, "R8 counts restarted", 64'(frame_lock), 0);
        send_mf(OP_GOOD, 403);
        chk(frame_lock, "R8 relock after four", 64'(frame_lock), 1);

        // R4: after a miss, a sync word on the very next block is taken
        do_reset();
        send_mf(OP_GOOD, 500);
        seq++; blk(2'b01, filler(seq), '0);
        for (int i = 0; i < 3; i++) send_mf(OP_GOOD, 501 + i);
        chk(!frame_lock, "R4 count restarted after miss", 64'(frame_lock), 0);
        sync_blk('0);
        chk(frame_lock, "R2/R4 search on next block", 64'(frame_lock), 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule